// File: doc/BRIEF.md
# Boot-Overlay Address Decoder

This block sits beside a 24-bit-address CPU bus and turns each strobed address into one active-low device select, or into a bus-error flag when nothing is mapped there. It never drives or samples data. The select outputs are registered: the address, strobe, strap and overlay inputs sampled at one rising clock edge set the outputs that hold until the next edge. The devices it selects are DMA-shared main memory, two peripheral timer/IO chips, optional trapdoor RAM, a real-time clock, the custom register block, the expansion configuration window and the boot ROM.

After reset a boot overlay is active. Accesses to the lowest 512 KB go to the boot ROM rather than main memory, so the CPU can fetch its reset vectors. A peripheral port bit is watched on every clock. When it is seen low, the overlay is dropped and main memory appears at address zero. Two strap pins choose the ROM size and say whether trapdoor RAM is fitted.

The address port carries only bits 23 down to 9. Bits 8 to 1 do not affect any decode, because no region boundary is finer than 512 bytes.

Top module: `boot_map_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every select is high and `berr_o` is low.
- R2: When `as_n` is sampled high, every select output is high and `berr_o` is low in the following cycle, whatever the address.
- R3: While the overlay is active (from reset onward), a strobed address in 0x000000–0x07FFFF asserts `rom_sel_n`. A strobed address in 0x080000–0x1FFFFF asserts `ram_sel_n`.
- R4: Sampling `ovl_i` low at a rising edge clears the overlay. The access sampled at that same edge still decodes with the overlay active. Later accesses in 0x000000–0x1FFFFF assert `ram_sel_n`. Once cleared, the overlay stays cleared until reset, even if `ovl_i` returns high.
- R5: When `strap_rom512` is 1, `rom_sel_n` covers 0xF80000–0xFFFFFF. When it is 0, `rom_sel_n` covers only 0xFC0000–0xFFFFFF, and 0xF80000–0xFBFFFF raises `berr_o`.
- R6: 0xBFD000–0xBFDFFF asserts `perb_sel_n`, and 0xBFE000–0xBFEFFF asserts `pera_sel_n`.
- R7: When `strap_trap` is 1, 0xC00000–0xC7FFFF asserts `trap_sel_n`. When it is 0, that range raises `berr_o`.
- R8: 0xDC0000–0xDCFFFF asserts `rtc_sel_n`. 0xDFF000–0xDFF1FF asserts `regs_sel_n`. 0xE80000–0xEFFFFF asserts `cfg_sel_n`.
- R9: Any strobed address outside the regions of R3–R8 raises `berr_o`, for example 0x200000, 0xA00000, 0xDFF200 and 0xF00000.
- R10: For every strobed address, exactly one of the eight selects or `berr_o` is asserted one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sets the overlay |
| addr_i | input | 15 | Address bits 23..9 |
| as_n | input | 1 | Active-low address strobe |
| ovl_i | input | 1 | Overlay bit from the peripheral port; low clears the overlay |
| strap_rom512 | input | 1 | 1 = 512 KB ROM, 0 = 256 KB ROM |
| strap_trap | input | 1 | 1 = trapdoor RAM fitted |
| ram_sel_n | output | 1 | Main DMA memory select |
| perb_sel_n | output | 1 | Peripheral chip B select |
| pera_sel_n | output | 1 | Peripheral chip A select |
| trap_sel_n | output | 1 | Trapdoor RAM enable |
| rtc_sel_n | output | 1 | Real-time clock select |
| regs_sel_n | output | 1 | Custom register block select |
| cfg_sel_n | output | 1 | Expansion configuration window select |
| rom_sel_n | output | 1 | Boot ROM select |
| berr_o | output | 1 | Unmapped access flag |

## Verification
An overlay clear and a low-memory access can fall in the same cycle. The bench provokes this by driving `ovl_i` low together with a strobed access to address 0x000000. The reference model expects that access to still select the ROM. The next access to the same address must select main memory, and so must a later one after `ovl_i` has gone high again. Each expected select vector is queued when its stimulus is driven, and the monitor compares it one edge later.

// File: rtl/bmd_pkg.sv
`timescale 1ns/1ps
package bmd_pkg;
  localparam int MAP_W = 24;

  typedef enum int {
    RG_RAM_LO, RG_RAM_HI, RG_OVL_ROM, RG_ROM_LO, RG_ROM_HI,
    RG_PERB, RG_PERA, RG_TRAP, RG_RTC, RG_REGS, RG_CFG, RG_COUNT
  } region_e;

  typedef enum int {
    DV_RAM, DV_PERB, DV_PERA, DV_TRAP, DV_RTC, DV_REGS, DV_CFG, DV_ROM, DV_COUNT
  } device_e;

  function automatic logic [MAP_W-1:0] region_lo(int idx);
    case (idx)
      RG_RAM_LO:  return 24'h000000;
      RG_RAM_HI:  return 24'h080000;
      RG_OVL_ROM: return 24'h000000;
      RG_ROM_LO:  return 24'hF80000;
      RG_ROM_HI:  return 24'hFC0000;
      RG_PERB:    return 24'hBFD000;
      RG_PERA:    return 24'hBFE000;
      RG_TRAP:    return 24'hC00000;
      RG_RTC:     return 24'hDC0000;
      RG_REGS:    return 24'hDFF000;
      default:    return 24'hE80000;
    endcase
  endfunction

  function automatic logic [MAP_W-1:0] region_hi(int idx);
    case (idx)
      RG_RAM_LO:  return 24'h07FFFF;
      RG_RAM_HI:  return 24'h1FFFFF;
      RG_OVL_ROM: return 24'h07FFFF;
      RG_ROM_LO:  return 24'hFBFFFF;
      RG_ROM_HI:  return 24'hFFFFFF;
      RG_PERB:    return 24'hBFDFFF;
      RG_PERA:    return 24'hBFEFFF;
      RG_TRAP:    return 24'hC7FFFF;
      RG_RTC:     return 24'hDCFFFF;
      RG_REGS:    return 24'hDFF1FF;
      default:    return 24'hEFFFFF;
    endcase
  endfunction

  function automatic int region_dev(int idx);
    case (idx)
      RG_RAM_LO, RG_RAM_HI:              return DV_RAM;
      RG_OVL_ROM, RG_ROM_LO, RG_ROM_HI:  return DV_ROM;
      RG_PERB:                           return DV_PERB;
      RG_PERA:                           return DV_PERA;
      RG_TRAP:                           return DV_TRAP;
      RG_RTC:                            return DV_RTC;
      RG_REGS:                           return DV_REGS;
      default:                           return DV_CFG;
    endcase
  endfunction
endpackage

// File: rtl/bmd_range_match.sv
`timescale 1ns/1ps
module bmd_range_match #(
  parameter int          KEY_W = 15,
  parameter logic [KEY_W-1:0] LO = '0,
  parameter logic [KEY_W-1:0] HI = '1
) (
  input  logic [KEY_W-1:0] key_i,
  input  logic             en_i,
  output logic             hit_o
);
  logic above_lo, below_hi;

  always_comb begin
    above_lo = (key_i >= LO);
    below_hi = (key_i <= HI);
    hit_o    = en_i & above_lo & below_hi;
  end
endmodule

// File: rtl/bmd_overlay.sv
`timescale 1ns/1ps
module bmd_overlay (
  input  logic clk,
  input  logic rst_n,
  input  logic ovl_i,
  output logic overlay_o
);
  logic overlay_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      overlay_q <= 1'b1;
    else if (!ovl_i) overlay_q <= 1'b0;
  end

  assign overlay_o = overlay_q;

  assert_ovl_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ovl_i |=> !overlay_o);
  assert_ovl_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !overlay_o |=> !overlay_o);
endmodule

// File: rtl/bmd_select_reg.sv
`timescale 1ns/1ps
module bmd_select_reg #(
  parameter int N_DEV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             as_n,
  input  logic [N_DEV-1:0] dev_hit_i,
  input  logic             miss_i,
  output logic [N_DEV-1:0] sel_o,
  output logic             berr_o
);
  logic [N_DEV-1:0] sel_q;
  logic             berr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      berr_q <= 1'b0;
    end else if (as_n) begin
      sel_q  <= '0;
      berr_q <= 1'b0;
    end else begin
      sel_q  <= dev_hit_i;
      berr_q <= miss_i;
    end
  end

  assign sel_o  = sel_q;
  assign berr_o = berr_q;

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |=> (sel_o == '0 && !berr_o));
  assert_one_hot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |=> ($countones({sel_o, berr_o}) == 1));
endmodule

// File: rtl/boot_map_decoder.sv
`timescale 1ns/1ps
module boot_map_decoder #(
  parameter int ADDR_W  = 24,
  parameter int DEC_LSB = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:DEC_LSB]   addr_i,
  input  logic                      as_n,
  input  logic                      ovl_i,
  input  logic                      strap_rom512,
  input  logic                      strap_trap,
  output logic                      ram_sel_n,
  output logic                      perb_sel_n,
  output logic                      pera_sel_n,
  output logic                      trap_sel_n,
  output logic                      rtc_sel_n,
  output logic                      regs_sel_n,
  output logic                      cfg_sel_n,
  output logic                      rom_sel_n,
  output logic                      berr_o
);
  import bmd_pkg::*;

  localparam int KEY_W = ADDR_W - DEC_LSB;
  localparam int N_REG = RG_COUNT;
  localparam int N_DEV = DV_COUNT;
  localparam logic [KEY_W-1:0] OVL_TOP  = KEY_W'(24'h07FFFF >> DEC_LSB);
  localparam logic [KEY_W-1:0] RLO_BASE = KEY_W'(24'hF80000 >> DEC_LSB);
  localparam logic [KEY_W-1:0] RLO_TOP  = KEY_W'(24'hFBFFFF >> DEC_LSB);

  logic             overlay;
  logic [N_REG-1:0] reg_en;
  logic [N_REG-1:0] reg_hit;
  logic [N_DEV-1:0] dev_hit;
  logic             miss;
  logic [N_DEV-1:0] sel;

  bmd_overlay u_overlay (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovl_i     (ovl_i),
    .overlay_o (overlay)
  );

  always_comb begin
    reg_en             = '1;
    reg_en[RG_RAM_LO]  = ~overlay;
    reg_en[RG_OVL_ROM] = overlay;
    reg_en[RG_ROM_LO]  = strap_rom512;
    reg_en[RG_TRAP]    = strap_trap;
  end

  for (genvar r = 0; r < N_REG; r++) begin : g_region
    bmd_range_match #(
      .KEY_W (KEY_W),
      .LO    (KEY_W'(region_lo(r) >> DEC_LSB)),
      .HI    (KEY_W'(region_hi(r) >> DEC_LSB))
    ) u_match (
      .key_i (addr_i),
      .en_i  (reg_en[r]),
      .hit_o (reg_hit[r])
    );
  end

  always_comb begin
    dev_hit = '0;
    for (int r = 0; r < N_REG; r++) begin
      if (reg_hit[r]) dev_hit[region_dev(r)] = 1'b1;
    end
    miss = ~|reg_hit;
  end

  bmd_select_reg #(.N_DEV(N_DEV)) u_select (
    .clk       (clk),
    .rst_n     (rst_n),
    .as_n      (as_n),
    .dev_hit_i (dev_hit),
    .miss_i    (miss),
    .sel_o     (sel),
    .berr_o    (berr_o)
  );

  assign ram_sel_n  = ~sel[DV_RAM];
  assign perb_sel_n = ~sel[DV_PERB];
  assign pera_sel_n = ~sel[DV_PERA];
  assign trap_sel_n = ~sel[DV_TRAP];
  assign rtc_sel_n  = ~sel[DV_RTC];
  assign regs_sel_n = ~sel[DV_REGS];
  assign cfg_sel_n  = ~sel[DV_CFG];
  assign rom_sel_n  = ~sel[DV_ROM];

  assert_boot_rom_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (overlay && !as_n && addr_i <= OVL_TOP) |=> (!rom_sel_n && ram_sel_n));
  assert_small_rom_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !strap_rom512 && addr_i >= RLO_BASE && addr_i <= RLO_TOP) |=> berr_o);
  assert_no_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strap_trap) |=> trap_sel_n);
endmodule

// File: tb/boot_map_decoder_bench.sv
`timescale 1ns/1ps
module boot_map_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        as_n = 1'b1;
  logic        ovl = 1'b1;
  logic        r512 = 1'b1;
  logic        trp = 1'b0;
  logic ram_n, perb_n, pera_n, trap_n, rtc_n, regs_n, cfg_n, rom_n, berr;

  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  bit   model_ovl = 1'b1;
  logic [8:0] q_exp[$];
  string      q_tag[$];

  always #10 clk = ~clk;

  boot_map_decoder u_boot_map_decoder (
    .clk(clk), .rst_n(rst_n), .addr_i(addr[23:9]), .as_n(as_n), .ovl_i(ovl),
    .strap_rom512(r512), .strap_trap(trp),
    .ram_sel_n(ram_n), .perb_sel_n(perb_n), .pera_sel_n(pera_n),
    .trap_sel_n(trap_n), .rtc_sel_n(rtc_n), .regs_sel_n(regs_n),
    .cfg_sel_n(cfg_n), .rom_sel_n(rom_n), .berr_o(berr)
  );

  // bit order: 0 ram,1 perb,2 pera,3 trap,4 rtc,5 regs,6 cfg,7 rom,8 berr
  function automatic logic [8:0] model(logic [23:0] a, logic s_n, bit ov, logic big, logic tp);
    logic [8:0] v = '0;
    if (s_n) return v;
    if (a <= 24'h07FFFF)                        v[ov ? 7 : 0] = 1'b1;
    else if (a <= 24'h1FFFFF)                   v[0] = 1'b1;
    else if (a >= 24'hBFD000 && a <= 24'hBFDFFF) v[1] = 1'b1;
    else if (a >= 24'hBFE000 && a <= 24'hBFEFFF) v[2] = 1'b1;
    else if (a >= 24'hC00000 && a <= 24'hC7FFFF && tp) v[3] = 1'b1;
    else if (a >= 24'hDC0000 && a <= 24'hDCFFFF) v[4] = 1'b1;
    else if (a >= 24'hDFF000 && a <= 24'hDFF1FF) v[5] = 1'b1;
    else if (a >= 24'hE80000 && a <= 24'hEFFFFF) v[6] = 1'b1;
    else if (a >= 24'hFC0000)                   v[7] = 1'b1;
    else if (a >= 24'hF80000 && big)            v[7] = 1'b1;
    if (v == '0) v[8] = 1'b1;
    return v;
  endfunction

  function automatic logic [8:0] observed();
    return {berr, ~rom_n, ~cfg_n, ~regs_n, ~rtc_n, ~trap_n, ~pera_n, ~perb_n, ~ram_n};
  endfunction

  task automatic drive(input logic [23:0] a, input logic s_n, input logic ov_in,
                       input logic big, input logic tp, input string tag);
    @(negedge clk);
    addr = a; as_n = s_n; ovl = ov_in; r512 = big; trp = tp;
    q_exp.push_back(model(a, s_n, model_ovl, big, tp));
    q_tag.push_back(tag);
    if (!ov_in) model_ovl = 1'b0;
  endtask

  // monitor: compare one edge after stimulus
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_exp.size() > 0) begin
        logic [8:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        total++;
        if (observed() !== e) begin
          bad++;
          $display("FAIL %s addr=%h actual=%b expected=%b", t, addr, observed(), e);
        end
        total++;
        if ($countones(observed()) > 1) begin
          bad++;
          $display("FAIL R10 more than one output actual=%b expected=%b", observed(), e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] sweep[] = '{24'h200000, 24'h9FFFFF, 24'hA00000, 24'hBFCFFF,
      24'hBFD000, 24'hBFDFFF, 24'hBFE000, 24'hBFEFFF, 24'hBFF000, 24'hC00000,
      24'hDBFFFF, 24'hDC0000, 24'hDCFFFF, 24'hDD0000, 24'hDFEFFF, 24'hDFF000,
      24'hDFF1FE, 24'hDFF200, 24'hE7FFFF, 24'hE80000, 24'hEFFFFF, 24'hF00000,
      24'hF7FFFF, 24'hF80000, 24'hFFFFFF};
    repeat (3) @(posedge clk);
    #3;
    total++;
    if (observed() !== 9'b0) begin
      bad++; $display("FAIL R1 in reset actual=%b expected=%b", observed(), 9'b0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    total++;
    if (observed() !== 9'b0) begin
      bad++; $display("FAIL R1 after release actual=%b expected=%b", observed(), 9'b0);
    end
    // R2 strobe idle
    drive(24'h000000, 1'b1, 1'b1, 1'b1, 1'b0, "R2 idle low");
    // R3 overlay active
    drive(24'h000000, 1'b0, 1'b1, 1'b1, 1'b0, "R3 overlay base");
    drive(24'h07FFFE, 1'b0, 1'b1, 1'b1, 1'b0, "R3 overlay top");
    drive(24'h080000, 1'b0, 1'b1, 1'b1, 1'b0, "R3 ram above overlay");
    drive(24'h1FFFFF, 1'b0, 1'b1, 1'b1, 1'b0, "R3 ram top");
    // R6 R8 R9 R10 boundary sweep
    foreach (sweep[i]) drive(sweep[i], 1'b0, 1'b1, 1'b1, 1'b0, "R6 R8 R9 R10 sweep");
    drive(24'hBFE000, 1'b1, 1'b1, 1'b1, 1'b0, "R2 idle mapped");
    drive(24'hDFF000, 1'b0, 1'b1, 1'b1, 1'b0, "R8 regs after idle");
    drive(24'hDFF000, 1'b1, 1'b1, 1'b1, 1'b0, "R2 idle regs");
    // R5 small ROM
    drive(24'hF80000, 1'b0, 1'b1, 1'b0, 1'b0, "R5 small rom low hole");
    drive(24'hFBFFFF, 1'b0, 1'b1, 1'b0, 1'b0, "R5 small rom hole top");
    drive(24'hFC0000, 1'b0, 1'b1, 1'b0, 1'b0, "R5 small rom base");
    // R7 trapdoor
    drive(24'hC00000, 1'b0, 1'b1, 1'b1, 1'b0, "R7 trap absent");
    drive(24'hC00000, 1'b0, 1'b1, 1'b1, 1'b1, "R7 trap base");
    drive(24'hC7FFFF, 1'b0, 1'b1, 1'b1, 1'b1, "R7 trap top");
    drive(24'hC80000, 1'b0, 1'b1, 1'b1, 1'b1, "R9 above trap");
    // R4 overlay clear colliding with low access
    drive(24'h000000, 1'b0, 1'b0, 1'b1, 1'b0, "R4 same-cycle still rom");
    drive(24'h000000, 1'b0, 1'b1, 1'b1, 1'b0, "R4 ram after clear");
    drive(24'h07FFFF, 1'b0, 1'b1, 1'b1, 1'b0, "R4 ram sticky");
    drive(24'hF80000, 1'b0, 1'b1, 1'b1, 1'b0, "R5 big rom base");
    drive(24'h040000, 1'b1, 1'b1, 1'b1, 1'b0, "R2 idle");
    drive(24'h040000, 1'b0, 1'b1, 1'b1, 1'b0, "R4 ram mid");
    drive(24'h040000, 1'b1, 1'b1, 1'b1, 1'b0, "R2 idle end");
    repeat (3) @(posedge clk);
    #5;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule